// File: doc/BRIEF.md
# Banked Register Space with Indirect Burst RAM

This block is a byte-wide register space on a simple host bus with a 7-bit address, a write strobe and a read strobe. It has a control byte, and bit 4 of that byte selects one of two banks. The low part of the space always holds general-purpose RAM. In bank 0, the upper half also holds RAM. In bank 1, the upper half instead exposes an extended control byte and an indirect port into a larger RAM array.

The larger array is never mapped directly. The host loads a pointer through two byte registers, then reads or writes through a single data-port address. When the burst bit in the extended control byte is set, every data-port access moves the pointer to the next location, so a whole block can be streamed through one address. The pointer wraps at the end of the array. Pointer bits beyond the array size do not exist.

Top module: `bank_reg_space`

## Requirements
- R1: After reset, the control byte, the extended control byte, the pointer and `bus_rdata` are all 0x00.
- R2: A read (`bus_rd` high with `bus_wr` low) presents its data on `bus_rdata` after the next rising clock edge. `bus_rdata` keeps its value in every cycle without such a read, including cycles that carry writes.
- R3: The control byte at 0x0A is readable and writable in both banks. Its bit 4 selects bank 1 when 1 and bank 0 when 0.
- R4: Addresses 0x0E to 0x3F are general RAM in both banks. Addresses 0x40 to 0x7F are further general RAM in bank 0.
- R5: In bank 1, the extended control byte is read and written at 0x4A, and its bit 5 is the burst enable. The pointer low byte is at 0x50, the pointer high byte is at 0x51, and the data port is at 0x53. A data-port write stores into the array at the pointer, and a data-port read returns the array byte at the pointer.
- R6: With burst disabled, the pointer keeps its value across data-port reads and writes.
- R7: With burst enabled, each data-port read or write advances the pointer by one.
- R8: Advancing from the last array location (EXT_BYTES-1) gives pointer 0.
- R9: Pointer bits at and above log2(EXT_BYTES) are discarded on write and read back as 0. With EXT_BYTES = 2048, writing 0xFF to the high byte reads back as 0x07.
- R10: Addresses 0x00 to 0x09 and 0x0B to 0x0D read 0 and ignore writes, and so do bank-1 addresses from 0x40 to 0x7F other than 0x4A, 0x50, 0x51 and 0x53. While bank 1 is selected, the bank-0 RAM at 0x40 to 0x7F is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions check four rules on every cycle: the pointer step under burst (which also covers the wrap), the pointer hold without burst or without any access, that the bank bit changes only through a control-byte write, and that read data holds between reads. Only the bench scenarios can show the address decode. That covers which bank hides or reveals which byte, the contents kept in the RAM arrays, the truncation of pointer bits above the array size, and that bank-0 RAM survives a spell in bank 1.

// File: rtl/bank_reg_space.sv
module bank_reg_space #(
  parameter int EXT_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  localparam int AW        = $clog2(EXT_BYTES);
  localparam int UBASE     = 14;
  localparam int USIZE     = 128 - UBASE;
  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;
  localparam logic [6:0] A_CTRL  = 7'h0A;
  localparam logic [6:0] A_XCTRL = 7'h4A;
  localparam logic [6:0] A_PLO   = 7'h50;
  localparam logic [6:0] A_PHI   = 7'h51;
  localparam logic [6:0] A_PORT  = 7'h53;

  logic [7:0]    ctrl_q, xctrl_q;
  logic [AW-1:0] ptr;
  logic [7:0]    uram [USIZE];
  logic [7:0]    xram [EXT_BYTES];
  logic [7:0]    rd_mux;

  logic bank_sel, burst_en, in_uram, hit_x, hit_lo, hit_hi, hit_port, port_acc;
  logic [6:0]  uidx;
  logic [15:0] ptr_w, ptr_lo_w, ptr_hi_w;

  assign bank_sel = ctrl_q[BANK_BIT];
  assign burst_en = xctrl_q[BURST_BIT];
  assign ptr_w    = 16'(ptr);
  assign ptr_lo_w = {ptr_w[15:8], bus_wdata};
  assign ptr_hi_w = {bus_wdata, ptr_w[7:0]};
  assign uidx     = bus_addr - 7'(UBASE);
  assign in_uram  = (bus_addr >= 7'(UBASE)) && !(bank_sel && bus_addr[6]);
  assign hit_x    = bank_sel && bus_addr == A_XCTRL;
  assign hit_lo   = bank_sel && bus_addr == A_PLO;
  assign hit_hi   = bank_sel && bus_addr == A_PHI;
  assign hit_port = bank_sel && bus_addr == A_PORT;
  assign port_acc = hit_port && (bus_wr || bus_rd);

  always_comb begin
    rd_mux = 8'h00;
    if (in_uram)                rd_mux = uram[uidx];
    else if (bus_addr == A_CTRL) rd_mux = ctrl_q;
    else if (hit_x)             rd_mux = xctrl_q;
    else if (hit_lo)            rd_mux = ptr_w[7:0];
    else if (hit_hi)            rd_mux = ptr_w[15:8];
    else if (hit_port)          rd_mux = xram[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 8'h00;
      xctrl_q   <= 8'h00;
      ptr       <= '0;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_wr) begin
        if (bus_addr == A_CTRL) ctrl_q  <= bus_wdata;
        if (hit_x)              xctrl_q <= bus_wdata;
        if (hit_lo)             ptr     <= ptr_lo_w[AW-1:0];
        if (hit_hi)             ptr     <= ptr_hi_w[AW-1:0];
      end
      if (port_acc && burst_en) ptr <= ptr + 1'b1;
      if (bus_rd && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && in_uram)  uram[uidx] <= bus_wdata;
    if (bus_wr && hit_port) xram[ptr]  <= bus_wdata;
  end
endmodule

// File: rtl/bank_reg_chk.sv
module bank_reg_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [7:0]    bus_rdata,
  input logic          bank_sel,
  input logic          burst_en,
  input logic [AW-1:0] ptr
);
  logic port_acc;
  assign port_acc = bank_sel && bus_addr == 7'h53 && (bus_wr || bus_rd);

  // R7 and R8: step by one, wrapping modulo the array size
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && burst_en) |=> ptr == AW'($past(ptr) + 1'b1));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !burst_en) |=> $stable(ptr));

  assert_ptr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> $stable(ptr));

  assert_bank_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 7'h0A) |=> $stable(bank_sel));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |=> $stable(bus_rdata));
endmodule

bind bank_reg_space bank_reg_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bank_sel(bank_sel),
  .burst_en(burst_en), .ptr(ptr)
);

// File: tb/bank_reg_space_bench.sv
module bank_reg_space_bench;
  localparam int EB = 2048;
  localparam logic [7:0] HIMASK = 8'((EB >> 8) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  bank_reg_space #(.EXT_BYTES(EB)) u_bank_reg_space (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial forever begin
    @(posedge clk);
    if (rst_n && bus_rd && !bus_wr) begin
      #5;
      if (exp_q.size() == 0) chk(bus_rdata, 8'hxx, "scoreboard empty");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(bus_rdata, 8'h00, "R1 rdata after reset");
    rd(7'h0A, 8'h00, "R1 control");
    wr(7'h0A, 8'h5A);
    rd(7'h0A, 8'h5A, "R3 control readback");
    rd(7'h4A, 8'h00, "R1 ext control");
    rd(7'h50, 8'h00, "R1 pointer low");
    rd(7'h51, 8'h00, "R1 pointer high");

    wr(7'h0A, 8'h00);
    wr(7'h0E, 8'h11); wr(7'h3F, 8'h22); wr(7'h40, 8'h33);
    wr(7'h7F, 8'h44); wr(7'h50, 8'h55); wr(7'h4A, 8'h66);
    rd(7'h0E, 8'h11, "R4 ram 0x0E"); rd(7'h3F, 8'h22, "R4 ram 0x3F");
    rd(7'h40, 8'h33, "R4 ram 0x40"); rd(7'h7F, 8'h44, "R4 ram 0x7F");
    rd(7'h50, 8'h55, "R4 ram 0x50"); rd(7'h4A, 8'h66, "R4 ram 0x4A");
    wr(7'h05, 8'hFF);
    rd(7'h05, 8'h00, "R10 reserved 0x05");
    rd(7'h0B, 8'h00, "R10 reserved 0x0B");

    wr(7'h0A, 8'h10);
    rd(7'h0E, 8'h11, "R4 low ram in bank1");
    rd(7'h4A, 8'h00, "R5 ext control in bank1");
    wr(7'h60, 8'hAA);
    rd(7'h60, 8'h00, "R10 bank1 unmapped");

    wr(7'h50, 8'h10); wr(7'h51, 8'h02);
    wr(7'h53, 8'hA1); wr(7'h53, 8'hA2);
    rd(7'h53, 8'hA2, "R6 port same location");
    rd(7'h50, 8'h10, "R6 pointer low held");
    rd(7'h51, 8'h02, "R6 pointer high held");
    rd(7'h53, 8'hA2, "R6 port reread");

    repeat (3) @(negedge clk);
    chk(bus_rdata, 8'hA2, "R2 hold while idle");
    wr(7'h0E, 8'h77);
    chk(bus_rdata, 8'hA2, "R2 hold across write");

    wr(7'h4A, 8'h20);
    rd(7'h4A, 8'h20, "R5 ext control readback");
    wr(7'h50, 8'h00); wr(7'h51, 8'h01);
    wr(7'h53, 8'hB0); wr(7'h53, 8'hB1); wr(7'h53, 8'hB2);
    rd(7'h50, 8'h03, "R7 pointer after burst writes");
    rd(7'h51, 8'h01, "R7 pointer high after burst");
    wr(7'h50, 8'h00);
    rd(7'h53, 8'hB0, "R7 burst read 0");
    rd(7'h53, 8'hB1, "R7 burst read 1");
    rd(7'h53, 8'hB2, "R7 burst read 2");
    rd(7'h50, 8'h03, "R7 pointer after burst reads");

    wr(7'h50, 8'hFF); wr(7'h51, 8'h07);
    wr(7'h53, 8'hC0);
    rd(7'h50, 8'h00, "R8 wrap low");
    rd(7'h51, 8'h00, "R8 wrap high");
    wr(7'h53, 8'hC1);
    wr(7'h50, 8'hFF); wr(7'h51, 8'h07);
    rd(7'h53, 8'hC0, "R8 last location");
    rd(7'h53, 8'hC1, "R8 wrapped to zero");
    rd(7'h50, 8'h01, "R8 pointer after wrap");

    wr(7'h51, 8'hFF);
    rd(7'h51, HIMASK, "R9 high bits dropped");
    wr(7'h51, 8'h0A);
    rd(7'h51, 8'h0A & HIMASK, "R9 high byte masked");
    wr(7'h53, 8'hD0);
    wr(7'h51, 8'h02); wr(7'h50, 8'h01);
    rd(7'h53, 8'hD0, "R9 alias location");

    wr(7'h0A, 8'h00);
    rd(7'h50, 8'h55, "R10 bank0 ram kept");
    rd(7'h4A, 8'h66, "R10 bank0 ram 0x4A kept");
    rd(7'h0E, 8'h77, "R4 low ram written in bank1");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule